// File: doc/BRIEF.md
# Privilege and Program Interrupt Unit

This block sits after instruction decode and judges every operation handed to it by a valid strobe. It flags a fault when a supervisor-only operation arrives while the machine runs in user mode, or when decode has marked the instruction illegal. On a fault it takes a program interrupt in the same clock edge. The current instruction address is saved, and a copy of the machine state is saved with a reason bit. A fixed interrupt machine state is built, and the next fetch address is forced to the shared program-interrupt vector.

An attention operation that is not trapped stops the unit with a sticky halt. From then on every strobe is ignored until reset. When an operation needs no interrupt, the unit passes the incoming machine state and the operation's own next address through unchanged.

Bit positions in the 64-bit machine state words are given in MSB0 numbering: position 0 is the most significant bit. Every position is a parameter.

Top module: `priv_trap_unit`

## Requirements
- R1: `op_i` is encoded as 0 plain, 1 attention, 2 read-state, 3 write-state, 4 write-state-doubleword, 5 interrupt-return, 6 read-special-register, 7 write-special-register. Codes 1 to 5 are privileged. When any of them arrives with the user-mode bit (MSB0 49) of `msr_i` set to 1, it traps.
- R2: Codes 6 and 7 are privileged only when `spr_hi_i` is 1. With `spr_hi_i` at 0 they never trap on privilege.
- R3: Privileged operations with the user-mode bit at 0 do not trap, and neither does code 0.
- R4: On a trap, `srr0_o` takes `cia_i`. `srr1_o` takes `msr_i` with the reason bit set: MSB0 45 for privilege and MSB0 44 for illegal. All other bits are copied.
- R5: On a trap, `nia_o` is 0x700 whatever `nia_i` carries.
- R6: On a trap, `msr_o` is `msr_i` with MSB0 bits 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62 and 5 cleared and bits 0 and 63 set. All other bits are kept.
- R7: `illegal_i` at 1 traps with the illegal reason. When a privilege fault occurs in the same operation, the privilege reason wins and only MSB0 45 is added.
- R8: An attention operation that does not trap sets `halt_o`, which stays at 1 until reset. While `halt_o` is 1, strobes change no output and raise no trap. An illegal attention traps and does not halt.
- R9: A strobe without a trap drives `msr_o` to `msr_i` and `nia_o` to `nia_i`, keeps `srr0_o` and `srr1_o`, and leaves `trap_o` at 0.
- R10: Outputs update on the clock edge where `valid_i` is 1. `trap_o` is high for exactly that one following cycle. With `valid_i` at 0 nothing changes. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation kind code |
| spr_hi_i | input | 1 | Top bit of the special-register number |
| illegal_i | input | 1 | Decode marked the instruction illegal |
| cia_i | input | 64 | Address of the current instruction |
| nia_i | input | 64 | Next address produced by the operation |
| msr_i | input | 64 | Current machine state |
| srr0_o | output | 64 | Saved instruction address |
| srr1_o | output | 64 | Saved machine state with reason bit |
| msr_o | output | 64 | Updated machine state |
| nia_o | output | 64 | Next fetch address |
| trap_o | output | 1 | One-cycle interrupt pulse |
| halt_o | output | 1 | Sticky halt |

## Verification
A privilege fault and an illegal-instruction flag can fall in the same strobe, and so can an attention with either fault. The bench drives privileged codes in user mode with `illegal_i` raised. It checks that only the privilege reason bit lands in the saved state. It also drives an illegal attention in supervisor mode and checks that a trap is taken while `halt_o` stays low. Once the unit has halted, a faulting operation is sent and must leave every output frozen.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  localparam int XLEN = 64;

  typedef enum logic [2:0] {
    OPK_PLAIN    = 3'd0,
    OPK_ATTN     = 3'd1,
    OPK_RD_STATE = 3'd2,
    OPK_WR_STATE = 3'd3,
    OPK_WR_STD   = 3'd4,
    OPK_IRET     = 3'd5,
    OPK_RD_SPEC  = 3'd6,
    OPK_WR_SPEC  = 3'd7
  } op_kind_e;

  // one-hot mask for an MSB0 bit position
  function automatic logic [XLEN-1:0] msb0_bit(input int unsigned pos);
    logic [XLEN-1:0] one;
    one = {{(XLEN-1){1'b0}}, 1'b1};
    return one << (XLEN - 1 - int'(pos));
  endfunction
endpackage

// File: rtl/priv_classify.sv
module priv_classify
  import priv_trap_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       spr_hi_i,
  output logic       is_priv_o,
  output logic       is_attn_o
);
  always_comb begin
    is_priv_o = 1'b0;
    is_attn_o = 1'b0;
    case (op_kind_e'(op_i))
      OPK_ATTN: begin
        is_priv_o = 1'b1;
        is_attn_o = 1'b1;
      end
      OPK_RD_STATE, OPK_WR_STATE, OPK_WR_STD, OPK_IRET: is_priv_o = 1'b1;
      OPK_RD_SPEC, OPK_WR_SPEC:                         is_priv_o = spr_hi_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/priv_trap_image.sv
module priv_trap_image
  import priv_trap_pkg::*;
#(
  parameter logic [XLEN-1:0] CLR_MASK = '0,
  parameter logic [XLEN-1:0] SET_MASK = '0
) (
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] msr_o
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (SET_MASK[b]) begin : g_set
      assign msr_o[b] = 1'b1;
    end else if (CLR_MASK[b]) begin : g_clr
      assign msr_o[b] = 1'b0;
    end else begin : g_keep
      assign msr_o[b] = msr_i[b];
    end
  end
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import priv_trap_pkg::*;
#(
  parameter logic [XLEN-1:0] VECTOR      = 64'h700,
  parameter int unsigned POS_WIDE      = 0,
  parameter int unsigned POS_UNDEF     = 5,
  parameter int unsigned POS_TXMEM     = 31,
  parameter int unsigned POS_VECU      = 38,
  parameter int unsigned POS_VSU       = 40,
  parameter int unsigned POS_RSN_ILL   = 44,
  parameter int unsigned POS_RSN_PRIV  = 45,
  parameter int unsigned POS_EXTIRQ    = 48,
  parameter int unsigned POS_USER      = 49,
  parameter int unsigned POS_FPU       = 50,
  parameter int unsigned POS_FPEXC0    = 52,
  parameter int unsigned POS_TRACE_S   = 53,
  parameter int unsigned POS_TRACE_E   = 54,
  parameter int unsigned POS_FPEXC1    = 55,
  parameter int unsigned POS_IXLATE    = 58,
  parameter int unsigned POS_DXLATE    = 59,
  parameter int unsigned POS_PERFMARK  = 61,
  parameter int unsigned POS_RECOV     = 62,
  parameter int unsigned POS_LITTLE    = 63
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic            spr_hi_i,
  input  logic            illegal_i,
  input  logic [63:0]     cia_i,
  input  logic [63:0]     nia_i,
  input  logic [63:0]     msr_i,
  output logic [63:0]     srr0_o,
  output logic [63:0]     srr1_o,
  output logic [63:0]     msr_o,
  output logic [63:0]     nia_o,
  output logic            trap_o,
  output logic            halt_o
);
  localparam int USER_IDX = XLEN - 1 - int'(POS_USER);
  localparam logic [XLEN-1:0] CLR_MASK =
      msb0_bit(POS_IXLATE) | msb0_bit(POS_DXLATE) | msb0_bit(POS_FPEXC0) |
      msb0_bit(POS_FPEXC1) | msb0_bit(POS_EXTIRQ) | msb0_bit(POS_RECOV) |
      msb0_bit(POS_TXMEM) | msb0_bit(POS_VECU) | msb0_bit(POS_VSU) |
      msb0_bit(POS_USER) | msb0_bit(POS_FPU) | msb0_bit(POS_PERFMARK) |
      msb0_bit(POS_TRACE_S) | msb0_bit(POS_TRACE_E) | msb0_bit(POS_UNDEF);
  localparam logic [XLEN-1:0] SET_MASK  = msb0_bit(POS_WIDE) | msb0_bit(POS_LITTLE);
  localparam logic [XLEN-1:0] RSN_PRIV  = msb0_bit(POS_RSN_PRIV);
  localparam logic [XLEN-1:0] RSN_ILL   = msb0_bit(POS_RSN_ILL);

  logic is_priv, is_attn;
  logic exec, priv_fault, ill_fault, take;
  logic [XLEN-1:0] trap_msr, reason;
  logic [XLEN-1:0] srr0_q, srr1_q, msr_q, nia_q;
  logic trap_q, halt_q;

  priv_classify u_cls (
    .op_i      (op_i),
    .spr_hi_i  (spr_hi_i),
    .is_priv_o (is_priv),
    .is_attn_o (is_attn)
  );

  priv_trap_image #(.CLR_MASK(CLR_MASK), .SET_MASK(SET_MASK)) u_img (
    .msr_i (msr_i),
    .msr_o (trap_msr)
  );

  // privilege fault outranks the illegal flag and the halt
  assign exec       = valid_i & ~halt_q;
  assign priv_fault = is_priv & msr_i[USER_IDX];
  assign ill_fault  = illegal_i & ~priv_fault;
  assign take       = priv_fault | ill_fault;
  assign reason     = priv_fault ? RSN_PRIV : RSN_ILL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srr0_q <= '0;
      srr1_q <= '0;
      msr_q  <= '0;
      nia_q  <= '0;
      trap_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      trap_q <= exec & take;
      if (exec) begin
        if (take) begin
          srr0_q <= cia_i;
          srr1_q <= msr_i | reason;
          msr_q  <= trap_msr;
          nia_q  <= VECTOR;
        end else begin
          msr_q  <= msr_i;
          nia_q  <= nia_i;
          if (is_attn) halt_q <= 1'b1;
        end
      end
    end
  end

  assign srr0_o = srr0_q;
  assign srr1_o = srr1_q;
  assign msr_o  = msr_q;
  assign nia_o  = nia_q;
  assign trap_o = trap_q;
  assign halt_o = halt_q;

  assert_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> nia_o == VECTOR);
  assert_msr_image_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ((msr_o & CLR_MASK) == '0) && ((msr_o & SET_MASK) == SET_MASK));
  assert_saved_cia_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> srr0_o == $past(cia_i));
  assert_reason_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (srr1_o & (RSN_PRIV | RSN_ILL)) != '0);
  assert_halt_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  assert_halt_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> !trap_o && $stable(msr_o) && $stable(nia_o));
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !trap_o && $stable(msr_o));
endmodule

// File: tb/sim_priv_trap_unit.sv
`timescale 1ns/1ps
module sim_priv_trap_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] op = '0;
  logic spr_hi = 1'b0;
  logic illegal = 1'b0;
  logic [63:0] cia = '0, nia = '0, msr = '0;
  logic [63:0] srr0, srr1, msr_out, nia_out;
  logic trap, halt;
  int checks = 0;
  int fails = 0;
  logic [63:0] e_srr0 = '0, e_srr1 = '0, e_msr = '0, e_nia = '0;

  always #2.5 clk = ~clk;

  priv_trap_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .spr_hi_i(spr_hi),
    .illegal_i(illegal), .cia_i(cia), .nia_i(nia), .msr_i(msr),
    .srr0_o(srr0), .srr1_o(srr1), .msr_o(msr_out), .nia_o(nia_out),
    .trap_o(trap), .halt_o(halt)
  );

  function automatic logic [63:0] mb(input int p);
    return 64'h1 << (63 - p);
  endfunction

  function automatic logic [63:0] trap_image(input logic [63:0] m);
    logic [63:0] r;
    r = m;
    foreach (CLR[k]) r &= ~mb(CLR[k]);
    r |= mb(0) | mb(63);
    return r;
  endfunction

  localparam int CLR [15] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62, 5};

  // op, spr_hi, illegal, user mode, expected reason (0 none, 1 priv, 2 illegal)
  localparam int NV = 14;
  localparam int V_OP  [NV] = '{0, 2, 3, 4, 5, 6, 6, 7, 7, 0, 2, 3, 1, 7};
  localparam int V_HI  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0};
  localparam int V_ILL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1};
  localparam int V_PR  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 0, 1, 1};
  localparam int V_RSN [NV] = '{0, 1, 1, 1, 1, 0, 1, 1, 0, 2, 1, 2, 1, 2};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(input int o, input int hi, input int ill, input logic [63:0] m,
                        input logic [63:0] c, input logic [63:0] n);
    @(negedge clk);
    valid = 1'b1; op = 3'(o); spr_hi = hi[0]; illegal = ill[0];
    msr = m; cia = c; nia = n;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic check_all(input string tag, input bit e_trap, input bit e_halt);
    chk(trap == e_trap, {tag, " trap"}, 64'(trap), 64'(e_trap));
    chk(halt == e_halt, {tag, " halt"}, 64'(halt), 64'(e_halt));
    chk(nia_out == e_nia, {tag, " nia"}, nia_out, e_nia);
    chk(msr_out == e_msr, {tag, " msr"}, msr_out, e_msr);
    chk(srr0 == e_srr0, {tag, " srr0"}, srr0, e_srr0);
    chk(srr1 == e_srr1, {tag, " srr1"}, srr1, e_srr1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] m, c, n;
    repeat (3) @(negedge clk);
    check_all("R10 reset", 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      m = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0001_0203_0405_0607);
      m = V_PR[i] != 0 ? (m | mb(49)) : (m & ~mb(49));
      m &= ~(mb(44) | mb(45));
      c = 64'h1000 + 64'(i) * 4;
      n = 64'h8000_0000 + 64'(i) * 16;
      strobe(V_OP[i], V_HI[i], V_ILL[i], m, c, n);
      case (V_RSN[i])
        0: tag = $sformatf("R1 R2 R3 R9 vec%0d", i);
        1: tag = $sformatf("R1 R2 R4 R5 R6 R7 vec%0d", i);
        default: tag = $sformatf("R4 R5 R6 R7 vec%0d", i);
      endcase
      if (V_RSN[i] == 0) begin
        e_msr = m; e_nia = n;
      end else begin
        e_msr = trap_image(m); e_nia = 64'h700; e_srr0 = c;
        e_srr1 = m | (V_RSN[i] == 1 ? mb(45) : mb(44));
      end
      check_all(tag, V_RSN[i] != 0, 1'b0);
    end

    // trap pulse lasts one cycle, idle strobe ignores illegal
    @(negedge clk);
    chk(trap == 1'b0, "R10 pulse end", 64'(trap), 64'h0);
    valid = 1'b0; illegal = 1'b1; msr = 64'hFFFF_0000_FFFF_0000; nia = 64'h1234;
    @(negedge clk);
    check_all("R10 no strobe", 1'b0, 1'b0);
    illegal = 1'b0;

    // illegal attention traps and does not halt
    m = 64'h0000_0000_0000_00F0;
    strobe(1, 0, 1, m, 64'h2000, 64'h2004);
    e_msr = trap_image(m); e_nia = 64'h700; e_srr0 = 64'h2000; e_srr1 = m | mb(44);
    check_all("R8 illegal attn", 1'b1, 1'b0);

    // attention in supervisor mode halts
    m = 64'h8000_0000_0000_0001;
    strobe(1, 0, 0, m, 64'h3000, 64'h3004);
    e_msr = m; e_nia = 64'h3004;
    check_all("R8 attn halt", 1'b0, 1'b1);

    // faulting and plain strobes after halt change nothing
    strobe(2, 0, 1, mb(49) | 64'h55, 64'h4000, 64'h4004);
    check_all("R8 halted fault", 1'b0, 1'b1);
    strobe(0, 0, 0, 64'h77, 64'h5000, 64'h5004);
    check_all("R8 halted plain", 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule